// File: doc/BRIEF.md
# Page Write Programming Sequencer

This block sits behind the serial slave front end of a byte-wide nonvolatile memory and ahead of the array model. For a write, the front end passes it the two word address bytes and then each received data byte. The block collects the bytes in a one-page buffer and tracks the byte position inside the page. When the write ends with a stop condition and at least one byte has been received, it hands the whole page to the array. That hand-off is one strobe that carries the page number, a per-byte mask and the buffered data. It then holds a busy flag for the full self-timed programming interval. The front end withholds every acknowledge while busy is high.

The array size is set by the density parameter, from 16 to 128 Kbit, and gives an 11 to 14 bit word address. Address bits above that width are discarded. The most significant bit of the high address byte chooses the configuration register region instead of the array. Data bytes in that region are left to other logic and never reach the page buffer. Between transactions, read strobes from the front end advance the same address counter linearly through the whole array.

Top module: `page_write_seq`

## Requirements
- R1: After reset, busy, prog_stb and cfg_sel are 0 and cur_addr is 0.
- R2: An address load sets cur_addr to {addr_hi, addr_lo} cut to the array's address width, so bits above that width have no effect. It sets cfg_sel to addr_hi bit 7.
- R3: In an array write, each data byte is stored at the page offset given by the low 5 bits of cur_addr, and cur_addr then advances by one. Those 5 bits wrap from 31 to 0 and the page bits above them never change.
- R4: A stop condition that ends an array write with at least one data byte raises prog_stb for exactly one cycle, in the cycle after the stop. With it, prog_page is the page of the transaction. prog_mask bit i is 1 exactly when offset i was written. Byte lane i of prog_data (bits 8i+7 to 8i) holds the last byte written to offset i.
- R5: A stop with no data bytes, or an abort, produces no strobe and no busy. Bytes of a discarded transaction do not show up in the mask of a later commit.
- R6: busy rises together with prog_stb and stays high for exactly PROG_CYCLES clock cycles.
- R7: While busy is high, address loads, data bytes, read strobes and stop or abort inputs are ignored. cur_addr does not change and no further strobe occurs.
- R8: When addr_hi bit 7 was 1 at the address load, data bytes do not move cur_addr and the closing stop produces no strobe.
- R9: A read strobe advances cur_addr by one across page boundaries, and wraps from the last array byte to 0.
- R10: When busy falls, cur_addr is one past the last byte written, taken within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_load | input | 1 | Pulse: both word address bytes are valid, a write transaction opens |
| addr_hi | input | 8 | High word address byte; bit 7 selects the configuration region |
| addr_lo | input | 8 | Low word address byte |
| data_valid | input | 1 | Pulse: a write data byte is valid |
| data_in | input | DATA_W | Write data byte |
| rd_advance | input | 1 | Pulse: a byte has been read, step the address |
| bus_stop | input | 1 | Pulse: stop condition ends the transaction |
| bus_abort | input | 1 | Pulse: the transaction ended without a stop and is dropped |
| busy | output | 1 | Programming cycle in progress; the front end withholds acknowledges |
| cfg_sel | output | 1 | The current transaction addresses the configuration region |
| cur_addr | output | ADDR_W | Current word address |
| prog_stb | output | 1 | One-cycle commit strobe to the array |
| prog_page | output | ADDR_W-5 | Page number being programmed |
| prog_mask | output | PAGE_BYTES | Per-offset write mask of the commit |
| prog_data | output | PAGE_BYTES*DATA_W | Page data; lane i in bits 8i+7 to 8i |

## Verification
Writes are tried with a single byte, with an aligned full page, with a run that starts near the end of a page and overruns it, and with random start offsets and lengths from 0 to 44 bytes. Together these separate correct in-page wrapping and last-writer-wins lanes from a counter that carries into the page bits or a mask that loses early bytes. Addresses with spare high bits set, configuration-region writes, empty and aborted transactions show that the ignore and discard paths leave the address and the strobe alone. Traffic injected during busy, and read strobes at a page edge and at the array end, separate the hold behaviour from the linear address stepping.

// File: rtl/pws_pkg.sv
package pws_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_FILL = 2'd1,
      PH_CFG  = 2'd2
   } phase_t;

   function automatic int unsigned addr_bits(input int unsigned kbit);
      return $clog2(kbit * 1024 / 8);
   endfunction

endpackage

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
   parameter int unsigned PAGE_BYTES = 32,
   parameter int unsigned DATA_W     = 8,
   localparam int unsigned OFS_W     = $clog2(PAGE_BYTES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr,
   input  logic                           wr_en,
   input  logic [OFS_W-1:0]               wr_ofs,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [PAGE_BYTES-1:0]          mask,
   output logic [PAGE_BYTES*DATA_W-1:0]   data
);

   logic [PAGE_BYTES-1:0] lane_we;

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_dec
      assign lane_we[i] = wr_en && (wr_ofs == OFS_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
      end else if (clr) begin
         mask <= '0;
      end else begin
         mask <= mask | lane_we;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
         if (lane_we[i]) begin
            data[i*DATA_W +: DATA_W] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/pws_addr_ctr.sv
module pws_addr_ctr #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned OFS_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_page,
   input  logic              step_lin,
   output logic [ADDR_W-1:0] addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_val;
      end else if (step_page) begin
         addr[OFS_W-1:0] <= addr[OFS_W-1:0] + 1'b1;
      end else if (step_lin) begin
         addr <= addr + 1'b1;
      end
   end

endmodule

// File: rtl/pws_prog_timer.sv
module pws_prog_timer #(
   parameter int unsigned PROG_CYCLES = 500000,
   localparam int unsigned CNT_W      = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   if (PROG_CYCLES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy <= 1'b0;
         else        busy <= start;
      end
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(PROG_CYCLES - 1);
         end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
   import pws_pkg::*;
#(
   parameter int unsigned DENSITY_KBIT = 16,
   parameter int unsigned PAGE_BYTES   = 32,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PROG_CYCLES  = 500000,
   localparam int unsigned ADDR_W      = addr_bits(DENSITY_KBIT),
   localparam int unsigned OFS_W       = $clog2(PAGE_BYTES),
   localparam int unsigned PAGE_W      = ADDR_W - OFS_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           addr_load,
   input  logic [7:0]                     addr_hi,
   input  logic [7:0]                     addr_lo,
   input  logic                           data_valid,
   input  logic [DATA_W-1:0]              data_in,
   input  logic                           rd_advance,
   input  logic                           bus_stop,
   input  logic                           bus_abort,
   output logic                           busy,
   output logic                           cfg_sel,
   output logic [ADDR_W-1:0]              cur_addr,
   output logic                           prog_stb,
   output logic [PAGE_W-1:0]              prog_page,
   output logic [PAGE_BYTES-1:0]          prog_mask,
   output logic [PAGE_BYTES*DATA_W-1:0]   prog_data
);

   initial begin : p_param_chk
      assert (DENSITY_KBIT == 16 || DENSITY_KBIT == 32 ||
              DENSITY_KBIT == 64 || DENSITY_KBIT == 128)
         else $error("DENSITY_KBIT must be 16, 32, 64 or 128");
      assert (PAGE_BYTES == 32)
         else $error("PAGE_BYTES must be 32");
      assert (DATA_W == 8)
         else $error("DATA_W must be 8");
      assert (PROG_CYCLES >= 1)
         else $error("PROG_CYCLES must be at least 1");
   end

   phase_t                         phase;
   logic [15:0]                    word_addr;
   logic                           unused_hi;
   logic                           lo_go, wr_go, rd_go, stop_go, abort_go;
   logic                           commit, clr_buf;
   logic [PAGE_BYTES-1:0]          buf_mask;
   logic [PAGE_BYTES*DATA_W-1:0]   buf_data;

   assign word_addr = {addr_hi, addr_lo};
   assign unused_hi = ^word_addr[14:ADDR_W];

   // Input qualification: nothing is taken while programming runs.
   assign lo_go    = !busy && addr_load;
   assign stop_go  = !busy && !addr_load && bus_stop;
   assign abort_go = !busy && !addr_load && !bus_stop && bus_abort;
   assign wr_go    = !busy && !addr_load && !bus_stop && !bus_abort &&
                     data_valid && (phase == PH_FILL);
   assign rd_go    = !busy && !addr_load && !data_valid && rd_advance;
   assign commit   = stop_go && (phase == PH_FILL) && (buf_mask != '0);
   assign clr_buf  = lo_go || stop_go || abort_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cfg_sel <= 1'b0;
      end else if (lo_go) begin
         phase   <= addr_hi[7] ? PH_CFG : PH_FILL;
         cfg_sel <= addr_hi[7];
      end else if (stop_go || abort_go) begin
         phase   <= PH_IDLE;
      end
   end

   pws_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (lo_go),
      .load_val  (word_addr[ADDR_W-1:0]),
      .step_page (wr_go),
      .step_lin  (rd_go),
      .addr      (cur_addr)
   );

   pws_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_buf),
      .wr_en   (wr_go),
      .wr_ofs  (cur_addr[OFS_W-1:0]),
      .wr_data (data_in),
      .mask    (buf_mask),
      .data    (buf_data)
   );

   pws_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (commit),
      .busy  (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_stb  <= 1'b0;
         prog_page <= '0;
         prog_mask <= '0;
      end else begin
         prog_stb <= commit;
         if (commit) begin
            prog_page <= cur_addr[ADDR_W-1:OFS_W];
            prog_mask <= buf_mask;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (commit) prog_data <= buf_data;
   end

endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned OFS_W       = 5,
   parameter int unsigned PAGE_BYTES  = 32,
   parameter int unsigned PROG_CYCLES = 500000
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  busy,
   input logic                  prog_stb,
   input logic [PAGE_BYTES-1:0] prog_mask,
   input logic [ADDR_W-1:0]     cur_addr,
   input logic                  cfg_sel,
   input logic                  addr_load,
   input logic                  data_valid,
   input logic                  rd_advance
);

   int unsigned run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      else           run_len <= 0;
   end

   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      prog_stb |=> !prog_stb);

   a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      prog_stb |-> (prog_mask != '0));

   a_r6_busy_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> prog_stb);

   a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == PROG_CYCLES));

   a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cur_addr));

   a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && data_valid && !addr_load && !rd_advance)
      |=> (cur_addr[ADDR_W-1:OFS_W] == $past(cur_addr[ADDR_W-1:OFS_W])));

   a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_sel && !addr_load && !rd_advance) |=> $stable(cur_addr));

endmodule

bind page_write_seq pws_checker #(
   .ADDR_W      (ADDR_W),
   .OFS_W       (OFS_W),
   .PAGE_BYTES  (PAGE_BYTES),
   .PROG_CYCLES (PROG_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .prog_stb   (prog_stb),
   .prog_mask  (prog_mask),
   .cur_addr   (cur_addr),
   .cfg_sel    (cfg_sel),
   .addr_load  (addr_load),
   .data_valid (data_valid),
   .rd_advance (rd_advance)
);

// File: tb/page_write_seq_tb.sv
module page_write_seq_tb;

   localparam int DENS = 16;
   localparam int PC   = 40;
   localparam int AW   = 11;
   localparam int PB   = 32;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          addr_load = 0, data_valid = 0, rd_advance = 0;
   logic          bus_stop = 0, bus_abort = 0;
   logic [7:0]    addr_hi = 0, addr_lo = 0, data_in = 0;
   logic          busy, cfg_sel, prog_stb;
   logic [AW-1:0] cur_addr;
   logic [AW-6:0] prog_page;
   logic [PB-1:0] prog_mask;
   logic [PB*8-1:0] prog_data;

   page_write_seq #(.DENSITY_KBIT(DENS), .PROG_CYCLES(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_hi(addr_hi),
      .addr_lo(addr_lo), .data_valid(data_valid), .data_in(data_in),
      .rd_advance(rd_advance), .bus_stop(bus_stop), .bus_abort(bus_abort),
      .busy(busy), .cfg_sel(cfg_sel), .cur_addr(cur_addr), .prog_stb(prog_stb),
      .prog_page(prog_page), .prog_mask(prog_mask), .prog_data(prog_data)
   );

   int errs = 0, checks = 0, stb_cnt = 0;
   bit done = 0;
   logic [AW-1:0] e_addr;
   logic          e_cfg;
   logic [PB-1:0] e_mask;
   logic [7:0]    e_buf [PB];

   always @(posedge clk) if (rst_n && prog_stb) stb_cnt++;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] f_addr(input logic [7:0] h, input logic [7:0] l);
      logic [15:0] w;
      w = {h, l};
      return w[AW-1:0];
   endfunction

   function automatic logic [AW-1:0] f_next(input logic [AW-1:0] a);
      return {a[AW-1:5], 5'(a[4:0] + 5'd1)};
   endfunction

   task automatic p_load(input logic [7:0] h, input logic [7:0] l);
      addr_hi = h; addr_lo = l; addr_load = 1;
      @(negedge clk); addr_load = 0;
   endtask
   task automatic p_data(input logic [7:0] d);
      data_in = d; data_valid = 1;
      @(negedge clk); data_valid = 0;
   endtask
   task automatic p_stop();
      bus_stop = 1; @(negedge clk); bus_stop = 0;
   endtask
   task automatic p_abort();
      bus_abort = 1; @(negedge clk); bus_abort = 0;
   endtask
   task automatic p_rd();
      rd_advance = 1; @(negedge clk); rd_advance = 0;
   endtask

   task automatic send_bytes(input int n);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         p_data(d);
         if (!e_cfg) begin
            e_buf[e_addr[4:0]] = d;
            e_mask[e_addr[4:0]] = 1'b1;
            e_addr = f_next(e_addr);
         end
      end
   endtask

   task automatic check_commit(input int base);
      int n;
      chk(prog_page == e_addr[AW-1:5], "R4", "page number", prog_page, e_addr[AW-1:5]);
      chk(prog_mask == e_mask, "R4", "byte mask", prog_mask, e_mask);
      for (int i = 0; i < PB; i++) begin
         if (e_mask[i])
            chk(prog_data[i*8 +: 8] == e_buf[i], "R4", "data lane",
                prog_data[i*8 +: 8], e_buf[i]);
      end
      chk(busy == 1'b1, "R6", "busy with strobe", busy, 1);
      n = 0;
      while (busy && n < PC + 10) begin
         n++;
         @(negedge clk);
      end
      chk(n == PC, "R6", "busy length", n, PC);
      chk(cur_addr == e_addr, "R10", "address after cycle", cur_addr, e_addr);
      chk(stb_cnt == base + 1, "R4", "one strobe", stb_cnt, base + 1);
   endtask

   task automatic run_txn(input logic [7:0] h, input logic [7:0] l,
                          input int n, input bit abrt);
      int base;
      bit commit;
      p_load(h, l);
      e_addr = f_addr(h, l); e_cfg = h[7]; e_mask = '0;
      chk(cur_addr == e_addr, "R2", "loaded address", cur_addr, e_addr);
      chk(cfg_sel == e_cfg, "R2", "region flag", cfg_sel, e_cfg);
      send_bytes(n);
      chk(cur_addr == e_addr, e_cfg ? "R8" : "R3", "address after data", cur_addr, e_addr);
      base = stb_cnt;
      if (abrt) p_abort(); else p_stop();
      commit = !abrt && !e_cfg && (e_mask != '0);
      chk(prog_stb == commit, commit ? "R4" : "R5", "commit strobe", prog_stb, commit);
      if (commit) begin
         check_commit(base);
      end else begin
         chk(busy == 1'b0, e_cfg ? "R8" : "R5", "no busy", busy, 0);
         repeat (2) @(negedge clk);
         chk(stb_cnt == base, e_cfg ? "R8" : "R5", "no strobe", stb_cnt, base);
      end
   endtask

   initial begin
      #(10 * 150000);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int base;
      void'($urandom(32'd4127));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1", "busy in reset", busy, 0);
      chk(prog_stb == 0, "R1", "strobe in reset", prog_stb, 0);
      chk(cur_addr == 0, "R1", "address in reset", cur_addr, 0);
      chk(cfg_sel == 0, "R1", "region in reset", cfg_sel, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_txn(8'h00, 8'h00, 1, 0);    // single byte
      run_txn(8'h03, 8'hE0, 32, 0);   // aligned full page
      run_txn(8'h02, 8'h1C, 40, 0);   // R3 overrun wraps inside page
      run_txn(8'h78, 8'h45, 3, 0);    // R2 spare high bits ignored
      run_txn(8'h80, 8'h10, 4, 0);    // R8 configuration region
      run_txn(8'h01, 8'h00, 0, 0);    // R5 empty write
      run_txn(8'h01, 8'h00, 5, 1);    // R5 aborted write
      run_txn(8'h01, 8'h08, 1, 0);    // R5 earlier bytes discarded

      // R7: traffic during busy is ignored
      p_load(8'h05, 8'h10);
      e_addr = f_addr(8'h05, 8'h10); e_cfg = 0; e_mask = '0;
      send_bytes(3);
      base = stb_cnt;
      p_stop();
      p_load(8'h02, 8'h40);
      p_data(8'hA5);
      p_rd();
      p_stop();
      chk(cur_addr == e_addr, "R7", "address held while busy", cur_addr, e_addr);
      while (busy) @(negedge clk);
      chk(stb_cnt == base + 1, "R7", "no extra strobe", stb_cnt, base + 1);
      chk(cur_addr == e_addr, "R10", "address after cycle", cur_addr, e_addr);

      // R9: linear read stepping
      p_load(8'h07, 8'hFE); p_abort();
      p_rd();
      chk(cur_addr == 11'h7FF, "R9", "read step", cur_addr, 11'h7FF);
      p_rd();
      chk(cur_addr == 11'h000, "R9", "array end wrap", cur_addr, 0);
      p_load(8'h00, 8'h1F); p_abort();
      p_rd();
      chk(cur_addr == 11'h020, "R9", "page crossing", cur_addr, 11'h020);

      // random transactions
      for (int t = 0; t < 25; t++) begin
         logic [7:0] h, l;
         h = 8'($urandom);
         h[7] = (($urandom % 6) == 0);
         l = 8'($urandom);
         run_txn(h, l, int'($urandom % 45), (($urandom % 8) == 0));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule